// File: doc/BRIEF.md
# Cascadable Eight-Line Interrupt Controller

This block gathers eight interrupt request lines and raises one interrupt output toward the processor. When the processor acknowledges, it returns the vector byte of the winning line. Priority is fixed, with line 0 the most urgent. Each line can be masked. It can be set to sample the rising edge of its request or the request level. An in-service register records which levels the processor is handling. That record holds back requests of equal or lower priority until software sends a specific end-of-interrupt for that level, unless automatic end-of-interrupt was chosen during setup.

Software reaches the block through a byte-wide port with three addresses. Address 0 carries commands and returns status. Address 1 carries the initialization words and later the mask. Address 2 holds the trigger-select register. A command byte with bit 4 set restarts the setup sequence. Two controllers can be chained: one is tied into the master role and the other into the slave role. The slave's interrupt output feeds a master line that is marked as cascaded. On acknowledge of that line, the master drives the line number onto the cascade bus, and the slave whose identity matches returns the vector.

Top module: `cascade_pic`

## Requirements
- R1: After reset the controller waits for setup: the mask reads 0xFF, `int_out` stays low whatever the request lines do, and an address-0 read returns the request register (IRR), which still follows the lines.
- R2: An address-0 write with data bit 4 set clears the in-service register (ISR) and the mask and selects IRR reads. The next address-1 writes are then taken in order: the vector base, then the cascade word (skipped when that command had bit 1 set), then the mode word (taken only when that command had bit 0 set). Once the sequence is complete, address-1 writes load the mask.
- R3: One cycle after an accepted acknowledge, `vec_valid` pulses for one cycle and `vec_out` holds the vector base plus the chosen line number.
- R4: A line is eligible when its IRR bit is set, its mask bit is clear, and no ISR bit of equal or higher priority (lower or equal index) is set. `int_out` is high exactly when the controller is set up and some line is eligible. Acknowledge picks the lowest-index eligible line.
- R5: An address-1 read returns the mask. A mask bit of 1 stops that line from raising `int_out`, but its IRR bit still records the request.
- R6: The command byte 0x0A selects IRR for address-0 reads, and 0x0B selects ISR.
- R7: The command byte 0x60 plus n (n = 0 to 7) clears ISR bit n and no other bit.
- R8: When mode-word bit 1 is set, an acknowledge leaves ISR unchanged.
- R9: An acknowledge with no eligible line returns the vector base plus 7 and leaves ISR unchanged, whether line 7 is masked or not.
- R10: Address 2 is the trigger-select register; a bit value of 1 selects level mode. In level mode an IRR bit is set on every cycle its line is high. In edge mode an IRR bit is set only by a low-to-high transition, so a line held high does not request again after its acknowledge. In both modes an IRR bit clears while its line is low.
- R11: In the master role, acknowledging a line whose cascade-word bit is 1 produces no `vec_valid`. Instead, for one cycle, `cas_en` is high and `cas_out` carries the line number.
- R12: In the slave role, cascade-word bits 2:0 are the slave identity. An acknowledge is accepted only while `cas_in` equals that identity. Any other acknowledge changes nothing and produces no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| master_role | input | 1 | 1 selects the master role, 0 the slave role |
| addr | input | 2 | Register address: 0 command/status, 1 setup/mask, 2 trigger select |
| wr_en | input | 1 | Write strobe for one cycle |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr` (combinational) |
| irq_in | input | 8 | Interrupt request lines |
| int_out | output | 1 | Interrupt request to the processor |
| ack | input | 1 | Acknowledge pulse from the processor |
| vec_valid | output | 1 | Vector returned this cycle |
| vec_out | output | 8 | Returned vector |
| cas_in | input | 3 | Cascade line number seen by a slave |
| cas_out | output | 3 | Cascade line number driven by a master |
| cas_en | output | 1 | Master drives `cas_out` this cycle |

## Verification
Directed patterns show the priority order on two simultaneous requests. Nested preemption by a higher line separates the specific end-of-interrupt from one that clears everything. Requests that disappear before acknowledge, tried both with line 7 masked and unmasked, expose the spurious path. A line held high through acknowledge is run in both trigger modes, which tells level capture from edge capture. Randomized mask and request patterns in level mode, mixed with random end-of-interrupt commands, build deep nesting of the in-service register. In each iteration the interrupt output, the vector and the ISR are compared against a bench model.

// File: rtl/cascade_pic.sv
module cascade_pic (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       master_role,
  input  logic [1:0] addr,
  input  logic       wr_en,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  input  logic [7:0] irq_in,
  output logic       int_out,
  input  logic       ack,
  output logic       vec_valid,
  output logic [7:0] vec_out,
  input  logic [2:0] cas_in,
  output logic [2:0] cas_out,
  output logic       cas_en
);

  typedef enum logic [2:0] {S_WAIT, S_BASE, S_CASC, S_MODE, S_RUN} setup_t;

  setup_t     st;
  logic [7:0] irr, isr, imr, trig, base, casc, prev;
  logic       need_casc, need_mode, aeoi, sel_isr;

  wire ready   = (st == S_RUN);
  wire wr_cmd  = wr_en && addr == 2'd0;
  wire wr_data = wr_en && addr == 2'd1;
  wire wr_trig = wr_en && addr == 2'd2;
  wire icw1    = wr_cmd && wdata[4];
  wire ocw3    = wr_cmd && !wdata[4] && wdata[3] && ready;
  wire seoi    = wr_cmd && !wdata[4] && !wdata[3] && wdata[7:5] == 3'b011 && ready;

  logic [7:0] elig;
  logic [2:0] pick;
  logic       any_elig;

  always_comb begin
    logic blk;
    blk = 1'b0;
    for (int i = 0; i < 8; i++) begin
      blk     = blk | isr[i];
      elig[i] = irr[i] & ~imr[i] & ~blk;
    end
    pick = 3'd7;
    for (int i = 7; i >= 0; i--)
      if (elig[i]) pick = 3'(i);
  end

  assign any_elig = |elig;
  assign int_out  = ready && any_elig;

  wire accept   = ack && ready && (master_role || cas_in == casc[2:0]);
  wire take     = accept && any_elig;
  wire to_slave = take && master_role && casc[pick];
  wire [7:0] take_mask = take ? (8'd1 << pick) : 8'd0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev <= 8'h00;
      irr  <= 8'h00;
    end else begin
      prev <= irq_in;
      irr  <= ((irr & ~take_mask) | (irq_in & ~prev) | (irq_in & trig)) & irq_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) isr <= 8'h00;
    else if (icw1) isr <= 8'h00;
    else begin
      logic [7:0] nx;
      nx = isr;
      if (take && !aeoi) nx = nx | take_mask;
      if (seoi) nx[wdata[2:0]] = 1'b0;
      isr <= nx;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) imr <= 8'hFF;
    else if (icw1) imr <= 8'h00;
    else if (wr_data && ready) imr <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) trig <= 8'h00;
    else if (wr_trig) trig <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_WAIT;
      base      <= 8'h00;
      casc      <= 8'h00;
      need_casc <= 1'b0;
      need_mode <= 1'b0;
      aeoi      <= 1'b0;
      sel_isr   <= 1'b0;
    end else if (icw1) begin
      st        <= S_BASE;
      casc      <= 8'h00;
      need_casc <= ~wdata[1];
      need_mode <= wdata[0];
      aeoi      <= 1'b0;
      sel_isr   <= 1'b0;
    end else begin
      if (ocw3 && wdata[1]) sel_isr <= wdata[0];
      if (wr_data) begin
        case (st)
          S_BASE: begin
            base <= wdata;
            st   <= need_casc ? S_CASC : (need_mode ? S_MODE : S_RUN);
          end
          S_CASC: begin
            casc <= wdata;
            st   <= need_mode ? S_MODE : S_RUN;
          end
          S_MODE: begin
            aeoi <= wdata[1];
            st   <= S_RUN;
          end
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vec_valid <= 1'b0;
      vec_out   <= 8'h00;
      cas_en    <= 1'b0;
      cas_out   <= 3'd0;
    end else begin
      vec_valid <= accept && !to_slave;
      cas_en    <= to_slave;
      if (accept) begin
        vec_out <= base + {5'd0, (any_elig ? pick : 3'd7)};
        cas_out <= pick;
      end
    end
  end

  always_comb begin
    case (addr)
      2'd0:    rdata = sel_isr ? isr : irr;
      2'd1:    rdata = imr;
      2'd2:    rdata = trig;
      default: rdata = 8'h00;
    endcase
  end

  a_r2_setup_clears: assert property (@(posedge clk) disable iff (!rst_n)
    icw1 |=> (isr == 8'h00 && imr == 8'h00 && st == S_BASE));
  a_r3_vector_follows_ack: assert property (@(posedge clk) disable iff (!rst_n)
    vec_valid |-> $past(ack));
  a_r5_mask_load: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_data && ready && !icw1) |=> imr == $past(wdata));
  a_r7_specific_eoi: assert property (@(posedge clk) disable iff (!rst_n)
    (seoi && !icw1) |=> !isr[$past(wdata[2:0])]);
  a_r8_auto_eoi: assert property (@(posedge clk) disable iff (!rst_n)
    (aeoi && ack && !seoi && !icw1) |=> isr == $past(isr));
  a_r9_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !any_elig && !seoi && !icw1) |=> (isr == $past(isr) && vec_out == $past(base) + 8'd7));
  a_r11_single_target: assert property (@(posedge clk) disable iff (!rst_n)
    !(vec_valid && cas_en));

endmodule

// File: tb/test_cascade_pic.sv
module test_cascade_pic;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       master_role = 1'b1;
  logic [1:0] addr = 2'd0;
  logic       wr_en = 1'b0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic [7:0] irq_in = 8'h00;
  logic       int_out;
  logic       ack = 1'b0;
  logic       vec_valid;
  logic [7:0] vec_out;
  logic [2:0] cas_in = 3'd0;
  logic [2:0] cas_out;
  logic       cas_en;

  int errors = 0;
  int checks = 0;

  always #2 clk = ~clk;

  cascade_pic i_cascade_pic (
    .clk(clk), .rst_n(rst_n), .master_role(master_role), .addr(addr),
    .wr_en(wr_en), .wdata(wdata), .rdata(rdata), .irq_in(irq_in),
    .int_out(int_out), .ack(ack), .vec_valid(vec_valid), .vec_out(vec_out),
    .cas_in(cas_in), .cas_out(cas_out), .cas_en(cas_en)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    addr = a;
    #1;
    d = rdata;
  endtask

  task automatic do_ack();
    @(negedge clk);
    ack = 1'b1;
    @(negedge clk);
    ack = 1'b0;
    #1;
  endtask

  task automatic setup(input logic [7:0] c, input logic [7:0] b, input logic [7:0] s, input logic [7:0] m);
    wr(2'd0, c); wr(2'd1, b); wr(2'd1, s); wr(2'd1, m);
  endtask

  function automatic logic [3:0] model_pick(input logic [7:0] r, input logic [7:0] m, input logic [7:0] s);
    for (int i = 0; i < 8; i++) begin
      if (s[i]) return 4'd8;
      if (r[i] && !m[i]) return 4'(i);
    end
    return 4'd8;
  endfunction

  initial begin
    #800000;
    errors++; checks++;
    $display("FAIL watchdog: got %h expected %h", 8'h01, 8'h00);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [7:0] v;
    void'($urandom(32'd2718));
    repeat (3) tick();
    rst_n = 1'b1;
    tick();

    // R1 waiting state
    irq_in = 8'h05; tick();
    chk("R1 int_out", {7'd0, int_out}, 8'h00);
    rd(2'd1, v); chk("R1 mask", v, 8'hFF);
    rd(2'd0, v); chk("R1 irr", v, 8'h05);
    irq_in = 8'h00; tick();

    // R2 setup, master, normal EOI
    setup(8'h11, 8'h20, 8'h04, 8'h01);
    rd(2'd1, v); chk("R2 mask cleared", v, 8'h00);

    // R4 priority, R3 vector, R6 ISR read
    irq_in = 8'h88; tick();
    chk("R4 int_out", {7'd0, int_out}, 8'h01);
    do_ack();
    chk("R3 valid", {7'd0, vec_valid}, 8'h01);
    chk("R3 vector", vec_out, 8'h23);
    wr(2'd0, 8'h0B);
    rd(2'd0, v); chk("R6 isr", v, 8'h08);
    chk("R4 blocked", {7'd0, int_out}, 8'h00);
    wr(2'd0, 8'h63);
    chk("R4 unblocked", {7'd0, int_out}, 8'h01);
    do_ack(); chk("R3 vector 7", vec_out, 8'h27);
    wr(2'd0, 8'h67);
    irq_in = 8'h00; tick();

    // R5 mask
    wr(2'd1, 8'h02);
    rd(2'd1, v); chk("R5 readback", v, 8'h02);
    irq_in = 8'h02; tick();
    chk("R5 masked", {7'd0, int_out}, 8'h00);
    irq_in = 8'h12; tick();
    chk("R5 other line", {7'd0, int_out}, 8'h01);
    do_ack(); chk("R5 vector", vec_out, 8'h24);
    wr(2'd0, 8'h64);
    wr(2'd1, 8'h00);
    chk("R5 recorded while masked", {7'd0, int_out}, 8'h01);
    do_ack(); chk("R5 vector after unmask", vec_out, 8'h21);
    wr(2'd0, 8'h61);
    irq_in = 8'h00; tick();

    // R7 nested, specific EOI
    irq_in = 8'h20; tick();
    do_ack(); chk("R7 vector 5", vec_out, 8'h25);
    irq_in = 8'h21; tick();
    chk("R4 preempt", {7'd0, int_out}, 8'h01);
    do_ack(); chk("R7 vector 0", vec_out, 8'h20);
    rd(2'd0, v); chk("R7 nested isr", v, 8'h21);
    wr(2'd0, 8'h65);
    rd(2'd0, v); chk("R7 only level 5", v, 8'h01);
    wr(2'd0, 8'h60);
    rd(2'd0, v); chk("R7 cleared", v, 8'h00);
    irq_in = 8'h00; tick();

    // R9 spurious
    irq_in = 8'h10; tick();
    chk("R9 raised", {7'd0, int_out}, 8'h01);
    irq_in = 8'h00; tick();
    chk("R10 request dropped", {7'd0, int_out}, 8'h00);
    do_ack();
    chk("R9 valid", {7'd0, vec_valid}, 8'h01);
    chk("R9 vector", vec_out, 8'h27);
    rd(2'd0, v); chk("R9 isr", v, 8'h00);
    wr(2'd1, 8'h80);
    irq_in = 8'h10; tick();
    irq_in = 8'h00; tick();
    do_ack(); chk("R9 vector masked 7", vec_out, 8'h27);
    rd(2'd0, v); chk("R9 isr masked 7", v, 8'h00);
    wr(2'd1, 8'h00);

    // R10 level versus edge
    wr(2'd2, 8'h01);
    rd(2'd2, v); chk("R10 trig readback", v, 8'h01);
    irq_in = 8'h01; tick();
    do_ack(); chk("R10 level vector", vec_out, 8'h20);
    wr(2'd0, 8'h60);
    wr(2'd0, 8'h0A);
    rd(2'd0, v); chk("R10 level irr", v, 8'h01);
    chk("R10 level retrigger", {7'd0, int_out}, 8'h01);
    wr(2'd2, 8'h00);
    do_ack(); chk("R10 edge vector", vec_out, 8'h20);
    wr(2'd0, 8'h60);
    tick();
    chk("R10 edge no retrigger", {7'd0, int_out}, 8'h00);
    rd(2'd0, v); chk("R10 edge irr", v, 8'h00);
    irq_in = 8'h00; tick();

    // R11 master cascade
    irq_in = 8'h04; tick();
    do_ack();
    chk("R11 no vector", {7'd0, vec_valid}, 8'h00);
    chk("R11 cas_en", {7'd0, cas_en}, 8'h01);
    chk("R11 cas_out", {5'd0, cas_out}, 8'h02);
    wr(2'd0, 8'h0B);
    rd(2'd0, v); chk("R11 isr", v, 8'h04);
    wr(2'd0, 8'h62);
    irq_in = 8'h00; tick();

    // R8 automatic EOI
    setup(8'h11, 8'h20, 8'h04, 8'h03);
    irq_in = 8'h40; tick();
    do_ack(); chk("R8 vector", vec_out, 8'h26);
    wr(2'd0, 8'h0B);
    rd(2'd0, v); chk("R8 isr", v, 8'h00);
    irq_in = 8'h41; tick();
    do_ack(); chk("R8 vector 0", vec_out, 8'h20);
    irq_in = 8'h00; tick();

    // R2 single mode skips cascade word
    wr(2'd0, 8'h13); wr(2'd1, 8'h40); wr(2'd1, 8'h01);
    rd(2'd1, v); chk("R2 single mask", v, 8'h00);
    wr(2'd1, 8'h5A);
    rd(2'd1, v); chk("R2 single mask load", v, 8'h5A);
    irq_in = 8'h01; tick();
    do_ack(); chk("R2 single vector", vec_out, 8'h40);
    irq_in = 8'h00; tick();

    // R12 slave identity
    master_role = 1'b0;
    setup(8'h11, 8'h28, 8'h02, 8'h01);
    irq_in = 8'h08; tick();
    cas_in = 3'd3;
    do_ack();
    chk("R12 other id valid", {7'd0, vec_valid}, 8'h00);
    chk("R12 other id cas_en", {7'd0, cas_en}, 8'h00);
    wr(2'd0, 8'h0B);
    rd(2'd0, v); chk("R12 other id isr", v, 8'h00);
    chk("R12 still requesting", {7'd0, int_out}, 8'h01);
    cas_in = 3'd2;
    do_ack();
    chk("R12 match valid", {7'd0, vec_valid}, 8'h01);
    chk("R12 match vector", vec_out, 8'h2B);
    irq_in = 8'h00; master_role = 1'b1; cas_in = 3'd0; tick();

    // Random: level mode, model of ISR
    setup(8'h11, 8'h30, 8'h00, 8'h01);
    wr(2'd2, 8'hFF);
    wr(2'd0, 8'h0B);
    begin
      logic [7:0] isr_m;
      isr_m = 8'h00;
      for (int n = 0; n < 300; n++) begin
        logic [7:0] m, r;
        logic [3:0] p;
        m = 8'($urandom);
        r = 8'($urandom);
        wr(2'd1, m);
        irq_in = r; tick();
        p = model_pick(r, m, isr_m);
        chk("R4 random int_out", {7'd0, int_out}, {7'd0, p != 4'd8});
        do_ack();
        if (p != 4'd8) begin
          chk("R3 random vector", vec_out, 8'h30 + {5'd0, p[2:0]});
          isr_m[p[2:0]] = 1'b1;
        end else begin
          chk("R9 random spurious", vec_out, 8'h37);
        end
        rd(2'd0, v); chk("R7 random isr", v, isr_m);
        if ($urandom_range(1, 0) == 1) begin
          logic [2:0] l;
          l = 3'($urandom);
          wr(2'd0, 8'h60 | {5'd0, l});
          isr_m[l] = 1'b0;
        end
      end
    end
    irq_in = 8'h00;
    tick();

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule